// File: doc/BRIEF.md
# Dual Countdown Timer Wrapper

This block places two countdown timers behind one 4 KB register window. A bus master reaches the first timer through the lowest 32 bytes and the second through the next 32 bytes, with the window base taken off before the access reaches the timer. The top 32 bytes of the space hold a read-only table of eight identification bytes, one per word. Two integration-test words return zero, and every other offset reads as zero and ignores writes.

Each timer has its own count-enable tick input, so the two can run at unrelated rates from one clock. Each timer has its own interrupt pin. A third pin is the OR of the two.

Each timer holds a reload value, a live count and a three-bit configuration. The configuration bits are run (bit 0), interrupt enable (bit 1) and single-shot (bit 2). It also holds a raw expiry flag and a masked version of that flag. Within a timer window, the word offsets are as follows: 0x00 is the reload (read/write; writing it also loads the count), 0x04 is the count (read), 0x08 is the configuration, 0x0C is the flag clear (write), 0x10 is the raw flag and 0x14 is the masked flag.

Top module: `dual_timer_wrap`

## Requirements
- R1: Offsets 0x00 to 0x1F address timer 0 only; a reload write at 0x00 shows at 0x00 and 0x04 and leaves timer 1 unchanged.
- R2: Offsets 0x20 to 0x3F address timer 1 at the offset minus 0x20; offset 0x40 is outside both windows.
- R3: Word offsets 0xFE0 to 0xFFC return one identification byte each, zero-extended to 32 bits. The first four are parameters that default to 0x04, 0x18, 0x14 and 0x00. The last four are 0x0D, 0xF0, 0x05 and 0xB1.
- R4: Offsets 0xF00 and 0xF04 read as zero, and writes to them change nothing.
- R5: Any other offset reads as zero, and a write to it changes no timer state.
- R6: `irq_any` is high whenever either per-timer interrupt is high.
- R7: `irq_unit[0]` and `irq_unit[1]` carry each timer's own interrupt.
- R8: A timer counts only on cycles where its own `tick` bit is high and its run bit is set.
- R9: After reset, reload, count and configuration read zero. A tick while the count is above zero decrements it. A tick at zero sets the raw flag and loads the reload value, so the period is reload+1 ticks.
- R10: In single-shot mode, a tick at zero sets the raw flag, clears the run bit and leaves the count at zero.
- R11: A write to the clear word drops the raw flag. The masked flag and the timer's interrupt are the raw flag ANDed with the interrupt-enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset in the register space |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero when not selected |
| tick | input | 2 | Per-timer count enable |
| irq_unit | output | 2 | Per-timer interrupt |
| irq_any | output | 1 | OR of both timer interrupts |

## Verification
A decode fault that routes a write to the wrong window shows on the very next read: the other timer's reload or count changes where it should not. A broken countdown shows within one tick as a count off by one, or as a flag that rises a tick early or late. A wrong expiry action shows the same cycle on `irq_unit`, because the interrupt follows the raw flag with no extra register. Faults in the identification table or in the zero-reading regions are combinational, and the read of the affected word exposes them at once.

// File: rtl/dtw_pkg.sv
package dtw_pkg;
  localparam int DW = 32;
  localparam int AW = 12;
  localparam int WIN_BITS = 5;                 // 32-byte timer window
  localparam logic [AW-1:WIN_BITS] WIN_T0 = '0;
  localparam logic [AW-1:WIN_BITS] WIN_T1 = 1;
  localparam logic [AW-1:WIN_BITS] WIN_ID = '1; // 0xFE0..0xFFF
  localparam logic [AW-1:2] TEST_W0 = 10'h3C0;  // 0xF00
  localparam logic [AW-1:2] TEST_W1 = 10'h3C1;  // 0xF04

  typedef enum logic [2:0] {
    W_RELOAD = 3'd0,
    W_COUNT  = 3'd1,
    W_CFG    = 3'd2,
    W_CLR    = 3'd3,
    W_RAW    = 3'd4,
    W_MASKED = 3'd5
  } word_e;

  typedef enum logic [2:0] {
    RG_NONE, RG_T0, RG_T1, RG_TEST, RG_ID
  } region_e;

  localparam int CFG_RUN    = 0;
  localparam int CFG_IRQEN  = 1;
  localparam int CFG_SINGLE = 2;

  // Identification byte for table slot idx; the low four come from a parameter.
  function automatic logic [7:0] id_byte(input logic [2:0] idx, input logic [31:0] low4);
    logic [7:0] b;
    case (idx)
      3'd4:    b = 8'h0D;
      3'd5:    b = 8'hF0;
      3'd6:    b = 8'h05;
      3'd7:    b = 8'hB1;
      default: b = low4[{idx[1:0], 3'b000} +: 8];
    endcase
    return b;
  endfunction
endpackage

// File: rtl/dtw_decode.sv
module dtw_decode
  import dtw_pkg::*;
(
  input  logic [AW-1:0] addr,
  output region_e       region,
  output logic [2:0]    word
);
  always_comb begin
    word = addr[4:2];
    if (addr[AW-1:WIN_BITS] == WIN_T0)       region = RG_T0;
    else if (addr[AW-1:WIN_BITS] == WIN_T1)  region = RG_T1;
    else if (addr[AW-1:WIN_BITS] == WIN_ID)  region = RG_ID;
    else if (addr[AW-1:2] == TEST_W0 || addr[AW-1:2] == TEST_W1) region = RG_TEST;
    else region = RG_NONE;
  end
endmodule

// File: rtl/dtw_countdown.sv
module dtw_countdown
  import dtw_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    word,
  input  logic [DW-1:0] wdata,
  input  logic          tick,
  output logic [DW-1:0] rdata,
  output logic          irq
);
  logic [CW-1:0] reload_q, cnt_q;
  logic run_q, irqen_q, single_q, raw_q;
  logic step, expire;

  assign step   = tick && run_q;
  assign expire = step && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reload_q <= '0;
      cnt_q    <= '0;
      run_q    <= 1'b0;
      irqen_q  <= 1'b0;
      single_q <= 1'b0;
      raw_q    <= 1'b0;
    end else begin
      if (expire) begin
        raw_q <= 1'b1;
        if (single_q) run_q <= 1'b0;
        else          cnt_q <= reload_q;
      end else if (step) begin
        cnt_q <= cnt_q - 1'b1;
      end
      if (wr_en) begin
        case (word)
          W_RELOAD: begin
            reload_q <= wdata[CW-1:0];
            cnt_q    <= wdata[CW-1:0];
          end
          W_CFG: begin
            run_q    <= wdata[CFG_RUN];
            irqen_q  <= wdata[CFG_IRQEN];
            single_q <= wdata[CFG_SINGLE];
          end
          W_CLR:   if (!expire) raw_q <= 1'b0;
          default: ;
        endcase
      end
    end
  end

  assign irq = raw_q && irqen_q;

  always_comb begin
    rdata = '0;
    case (word)
      W_RELOAD: rdata[CW-1:0] = reload_q;
      W_COUNT:  rdata[CW-1:0] = cnt_q;
      W_CFG:    rdata[2:0]    = {single_q, irqen_q, run_q};
      W_RAW:    rdata[0]      = raw_q;
      W_MASKED: rdata[0]      = irq;
      default:  rdata = '0;
    endcase
  end

  // R9: periodic expiry reloads the count
  p_reload_on_expiry_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !single_q && !wr_en) |=> (cnt_q == $past(reload_q)));
  // R10: single-shot expiry stops the timer at zero
  p_single_stops_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && single_q && !wr_en) |=> (!run_q && cnt_q == '0));
  // R8: no tick, no movement
  p_hold_without_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !wr_en) |=> $stable(cnt_q));
  // R11: expiry always leaves the raw flag set
  p_flag_on_expiry_r11: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> raw_q);
endmodule

// File: rtl/dual_timer_wrap.sv
module dual_timer_wrap
  import dtw_pkg::*;
#(
  parameter logic [31:0] ID_LOW = 32'h0014_1804,
  parameter int          CW     = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [11:0]   bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic [1:0]    tick,
  output logic [1:0]    irq_unit,
  output logic          irq_any
);
  localparam int NUNITS = 2;

  region_e    region;
  logic [2:0] word;
  logic [NUNITS-1:0] unit_hit, unit_we;
  logic [DW-1:0] unit_rd [NUNITS];

  dtw_decode dec_i (.addr(bus_addr), .region(region), .word(word));

  assign unit_hit[0] = (region == RG_T0);
  assign unit_hit[1] = (region == RG_T1);

  for (genvar u = 0; u < NUNITS; u++) begin : g_unit
    assign unit_we[u] = bus_sel && bus_wr && unit_hit[u];
    dtw_countdown #(.CW(CW)) tmr_i (
      .clk(clk), .rst_n(rst_n), .wr_en(unit_we[u]), .word(word),
      .wdata(bus_wdata), .tick(tick[u]), .rdata(unit_rd[u]), .irq(irq_unit[u])
    );
  end

  assign irq_any = |irq_unit;

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      case (region)
        RG_T0:   bus_rdata = unit_rd[0];
        RG_T1:   bus_rdata = unit_rd[1];
        RG_ID:   bus_rdata = {24'd0, id_byte(word, ID_LOW)};
        default: bus_rdata = '0;
      endcase
    end
  end

  // R5: at most one timer sees a write strobe, none outside the windows
  p_one_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(unit_we) && ((region == RG_NONE || region == RG_TEST) -> unit_we == '0));
  // R4: test words read zero
  p_test_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && region == RG_TEST) |-> (bus_rdata == '0));
  // R3: identification reads are zero-extended bytes
  p_id_byte_wide_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && region == RG_ID) |-> (bus_rdata[31:8] == '0));
  // R6: combined line follows either timer
  p_merge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_unit != 2'b00) |-> irq_any);
endmodule

// File: tb/dual_timer_wrap_tb_top.sv
`timescale 1ns/100ps
module dual_timer_wrap_tb_top;
  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_wr = 0;
  logic [11:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [1:0] tick = 0, irq_unit;
  logic irq_any;

  int total = 0, bad = 0;
  bit finished = 0, rd_go = 0;

  typedef struct { logic [11:0] a; logic [31:0] e; string tag; } item_t;
  item_t exp_q[$];

  always #2.5 clk = ~clk;

  dual_timer_wrap dut_i (.*);

  task automatic note(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: one read, expected value goes to the scoreboard
  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    exp_q.push_back('{a, e, tag});
    rd_go = 1;
    @(negedge clk);
    bus_sel = 0; rd_go = 0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic tk(input int u, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick[u] = 1;
      @(negedge clk); tick[u] = 0;
    end
  endtask

  task automatic pin(input logic [31:0] act_unused, input logic [2:0] exp, input string tag);
    @(negedge clk); #1;
    note({irq_any, irq_unit} == exp, tag, {29'd0, irq_any, irq_unit}, {29'd0, exp});
  endtask

  // monitor: pops and compares as reads complete
  initial forever begin
    @(negedge clk); #1;
    if (rd_go) begin
      item_t it;
      it = exp_q.pop_front();
      note(bus_rdata === it.e, it.tag, bus_rdata, it.e);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R9 reset state
    rd(12'h000, 0, "R9 reset reload");
    rd(12'h004, 0, "R9 reset count");
    rd(12'h008, 0, "R9 reset cfg");
    pin(0, 3'b000, "R7 reset irqs");
    // R3 identification table
    rd(12'hFE0, 32'h04, "R3 id0"); rd(12'hFE4, 32'h18, "R3 id1");
    rd(12'hFE8, 32'h14, "R3 id2"); rd(12'hFEC, 32'h00, "R3 id3");
    rd(12'hFF0, 32'h0D, "R3 id4"); rd(12'hFF4, 32'hF0, "R3 id5");
    rd(12'hFF8, 32'h05, "R3 id6"); rd(12'hFFC, 32'hB1, "R3 id7");
    // R4 test words
    wr(12'hF00, 32'hFFFF_FFFF); wr(12'hF04, 32'h1234_5678);
    rd(12'hF00, 0, "R4 test ctrl"); rd(12'hF04, 0, "R4 test out");
    rd(12'h000, 0, "R4 no side effect");
    // R1 / R2 windows
    wr(12'h000, 5);
    rd(12'h004, 5, "R1 count loaded");
    rd(12'h024, 0, "R1 other timer untouched");
    wr(12'h020, 2);
    rd(12'h020, 2, "R2 timer1 reload");
    rd(12'h000, 5, "R2 timer0 kept");
    // R5 undecoded
    wr(12'h100, 32'hDEAD); wr(12'h040, 32'h77);
    rd(12'h100, 0, "R5 undecoded read");
    rd(12'h040, 0, "R2 past window read");
    rd(12'h000, 5, "R5 timer0 intact");
    rd(12'h020, 2, "R5 timer1 intact");
    // R8 / R9 timer0 periodic with irq
    wr(12'h008, 3);
    tk(0, 3);
    rd(12'h004, 2, "R9 decrement");
    tk(1, 2);
    rd(12'h004, 2, "R8 foreign tick");
    rd(12'h024, 2, "R8 timer1 not running");
    tk(0, 2);
    rd(12'h004, 0, "R9 at zero");
    pin(0, 3'b000, "R9 no flag yet");
    tk(0, 1);
    rd(12'h004, 5, "R9 reload after expiry");
    pin(0, 3'b101, "R6 R7 timer0 irq");
    rd(12'h010, 1, "R11 raw");
    rd(12'h014, 1, "R11 masked");
    wr(12'h00C, 0);
    pin(0, 3'b000, "R11 cleared irq");
    rd(12'h010, 0, "R11 raw cleared");
    // R10 timer1 single shot, irq off
    wr(12'h028, 5);
    tk(1, 3);
    rd(12'h024, 0, "R10 count zero");
    rd(12'h030, 1, "R10 raw set");
    rd(12'h034, 0, "R11 masked off");
    rd(12'h028, 4, "R10 run cleared");
    pin(0, 3'b000, "R11 masked pin");
    tk(1, 1);
    rd(12'h024, 0, "R10 stays stopped");
    wr(12'h028, 2);
    pin(0, 3'b110, "R6 R7 timer1 irq");
    rd(12'h034, 1, "R11 masked on");
    wait (exp_q.size() == 0);
    @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule